// File: doc/BRIEF.md
# Scanning SAR Converter Sequencer

This block is the digital half of an eight-input successive-approximation converter. Software writes a control word that picks the inputs to convert, the clock divider, the resolution, the power state, and whether conversion runs once on command or keeps cycling. The block divides its clock into conversion ticks and points the external analog multiplexer at the chosen input. On each tick it drives a trial code to the external comparator and keeps or drops the trial bit according to the comparator's one-bit answer.

Each finished result goes to the data register of its input and to a global data register. Both kinds of register carry a DONE flag and an OVERRUN flag, and reading a register clears both of its flags. A level interrupt is raised while any input whose enable bit is set holds an unread result. The analog multiplexer, the sample-and-hold stage and the comparator lie outside the block.

Control word layout (24 bits): `[7:0]` input mask, `[15:8]` divider, `[16]` continuous scan, `[19:17]` resolution code, `[20]` power-on, `[23:21]` start code. Read word layout: `[31]` DONE, `[30]` OVERRUN, `[26:24]` input number (global register only, zero in the per-input registers), `[15:6]` result. The input register for input k sits at read address k. The global register sits at address 8. Addresses 9 to 15 read as zero and clear nothing.

Top module: `adc_scan_seq`

## Requirements
- R1: While powered on, `conv_tick` pulses for one clock once every divider+1 clocks. The count runs from the last pulse, or from power-on, and the tick fires when the count reaches the divider field. While powered off, `conv_tick` stays low.
- R2: A control write with start code 001, continuous scan off and power on starts one conversion of the lowest set mask input. `mux_sel` shows that input for the whole conversion.
- R3: Resolution code c gives 10-c result bits, and each conversion lasts 11-c conversion ticks. The result stays left-aligned in `[15:6]`, and the c lowest result bits read 0.
- R4: The result is the comparator-driven binary search over the trial code, with the comparator answering 1 when input ≥ trial. For a static input this yields the input value with its low bits truncated.
- R5: With continuous scan on and start code 000, conversions cycle through the set mask bits from lowest to highest and then wrap to the lowest. Each new control write restarts the walk at the lowest set bit.
- R6: Clearing continuous scan lets the conversion in progress finish and store its result. No further conversion begins.
- R7: With continuous scan on and a start code other than 000, no conversion begins.
- R8: With power-on at 0, no conversion begins. A conversion in progress is abandoned without storing a result.
- R9: The global register holds DONE, OVERRUN, the input number and the latest result of any input. Each input register holds the latest result of that input.
- R10: Reading a register clears its own DONE and OVERRUN in the next cycle. A result written in the same cycle takes precedence.
- R11: OVERRUN of a register is set when a result arrives with continuous scan on while that register's DONE is still set. It stays set until the register is read.
- R12: `irq` is high exactly while some input has DONE set and its bit in `irq_en` is set. After reset, `irq` and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 24 | Control word |
| irq_en | input | 8 | Per-input interrupt enable |
| rd_en | input | 1 | Read strobe (clears flags of the addressed register) |
| rd_addr | input | 4 | Read address: 0-7 input registers, 8 global |
| cmp_in | input | 1 | Comparator decision, 1 when input ≥ trial code |
| rd_data | output | 32 | Read word of the addressed register |
| conv_tick | output | 1 | Divided conversion clock enable |
| mux_sel | output | 3 | Input number for the analog multiplexer |
| trial_code | output | 10 | Trial code to the comparator DAC |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | End-of-conversion interrupt |

## Verification
The embedded properties check the following on every cycle:
- The tick never repeats on back-to-back clocks when the divider is non-zero.
- A finished result never carries bits below its resolution.
- `mux_sel` holds still during a conversion.
- No conversion starts without a software start or an allowed scan, and none runs while powered off.
- OVERRUN only rises over a set DONE.
- A global read clears both flags.

Some behaviours only the scenarios show: the scan order with its wrap, the exact result values for chosen input levels, the tick count per resolution, that a stopped scan still finishes its last conversion, and the interrupt masking.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NCH   = 8;
    localparam int CHW   = $clog2(NCH);
    localparam int RESW  = 10;
    localparam int DIVW  = 8;
    localparam int RCW   = 3;
    localparam int CTRLW = 24;
    localparam int WORDW = 32;

    localparam logic [2:0] GO_NOW = 3'b001;

    localparam int DONE_BIT = 31;
    localparam int OVR_BIT  = 30;
    localparam int CHN_LSB  = 24;
    localparam int VAL_LSB  = 6;

    // Control word, most significant field first
    typedef struct packed {
        logic [2:0]      go;
        logic            pwr_on;
        logic [RCW-1:0]  res;
        logic            scan;
        logic [DIVW-1:0] div;
        logic [NCH-1:0]  mask;
    } ctrl_t;

    typedef struct packed {
        logic            done;
        logic            ovr;
        logic [RESW-1:0] val;
    } slot_t;

    typedef enum logic [1:0] {SAR_IDLE, SAR_SAMPLE, SAR_BITS} sar_state_e;

    // Bits kept at a given resolution code: the code lowest bits are dropped
    function automatic logic [RESW-1:0] keep_mask(input logic [RCW-1:0] code);
        logic [RESW-1:0] m;
        for (int i = 0; i < RESW; i++) m[i] = (i >= int'(code));
        return m;
    endfunction

    // First set mask bit at or above 'from', wrapping around
    function automatic logic [CHW-1:0] next_set(input logic [NCH-1:0] mask,
                                                input logic [CHW-1:0] from);
        logic [CHW-1:0] pick;
        logic           found;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            int idx;
            idx = (int'(from) + k) % NCH;
            if (!found && mask[idx]) begin
                pick  = CHW'(idx);
                found = 1'b1;
            end
        end
        return pick;
    endfunction

    function automatic logic [WORDW-1:0] pack_word(input logic done, input logic ovr,
                                                   input logic [CHW-1:0] ch,
                                                   input logic [RESW-1:0] val);
        logic [WORDW-1:0] w;
        w = '0;
        w[DONE_BIT]          = done;
        w[OVR_BIT]           = ovr;
        w[CHN_LSB +: CHW]    = ch;
        w[VAL_LSB +: RESW]   = val;
        return w;
    endfunction
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
    import adc_seq_pkg::*;
#(
    parameter int DW = DIVW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt_q;

    assign tick = en && (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int RW = RESW,
    parameter int CW = CHW,
    parameter int RC = RCW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [CW-1:0] launch_ch,
    input  logic [RC-1:0] launch_res,
    input  logic          tick,
    input  logic          abort,
    input  logic          cmp_in,
    output logic          busy,
    output logic [CW-1:0] mux_ch,
    output logic [RW-1:0] trial,
    output logic          done_pulse,
    output logic [CW-1:0] done_ch,
    output logic [RW-1:0] done_val
);
    localparam int BW = $clog2(RW);

    sar_state_e    st_q;
    logic [BW-1:0] bit_q;
    logic [RW-1:0] acc_q;
    logic [RW-1:0] acc_next;
    logic [CW-1:0] ch_q;
    logic [RC-1:0] res_q;

    always_comb begin
        acc_next        = acc_q;
        acc_next[bit_q] = cmp_in;
    end

    assign trial  = (st_q == SAR_BITS) ? (acc_q | (RW'(1) << bit_q)) : '0;
    assign busy   = (st_q != SAR_IDLE);
    assign mux_ch = ch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SAR_IDLE;
            bit_q      <= '0;
            acc_q      <= '0;
            ch_q       <= '0;
            res_q      <= '0;
            done_pulse <= 1'b0;
            done_ch    <= '0;
            done_val   <= '0;
        end else begin
            done_pulse <= 1'b0;
            if (abort) begin
                st_q <= SAR_IDLE;
            end else begin
                case (st_q)
                    SAR_IDLE: if (launch) begin
                        st_q  <= SAR_SAMPLE;
                        ch_q  <= launch_ch;
                        res_q <= launch_res;
                        acc_q <= '0;
                    end
                    SAR_SAMPLE: if (tick) begin
                        st_q  <= SAR_BITS;
                        bit_q <= BW'(RW - 1);
                    end
                    SAR_BITS: if (tick) begin
                        acc_q <= acc_next;
                        if (bit_q == BW'(res_q)) begin
                            st_q       <= SAR_IDLE;
                            done_pulse <= 1'b1;
                            done_ch    <= ch_q;
                            done_val   <= acc_next;
                        end else begin
                            bit_q <= bit_q - 1'b1;
                        end
                    end
                    default: st_q <= SAR_IDLE;
                endcase
            end
        end
    end

    // R3
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> ((done_val & ~keep_mask(res_q)) == '0));

    // R2
    mux_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mux_ch));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int N  = NCH,
    parameter int CW = CHW,
    parameter int RW = RESW,
    parameter int AW = CHW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CW-1:0]    wr_ch,
    input  logic [RW-1:0]    wr_val,
    input  logic             wr_scan,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WORDW-1:0] rd_data,
    output logic [N-1:0]     ch_done
);
    localparam logic [AW-1:0] GADDR = AW'(N);

    slot_t         slot_v [N];
    slot_t         g_q;
    logic [CW-1:0] gch_q;
    logic          g_rd;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            slot_t s_q;
            logic  rd_hit;
            logic  wr_hit;
            logic  keep_done;
            logic  keep_ovr;

            assign rd_hit    = rd_en && (rd_addr == AW'(g));
            assign wr_hit    = wr && (wr_ch == CW'(g));
            assign keep_done = s_q.done && !rd_hit;
            assign keep_ovr  = s_q.ovr && !rd_hit;

            always_ff @(posedge clk) begin
                if (rst) begin
                    s_q <= '0;
                end else if (wr_hit) begin
                    s_q <= '{done: 1'b1, ovr: keep_ovr | (wr_scan & keep_done), val: wr_val};
                end else if (rd_hit) begin
                    s_q.done <= 1'b0;
                    s_q.ovr  <= 1'b0;
                end
            end

            assign slot_v[g]  = s_q;
            assign ch_done[g] = s_q.done;
        end
    endgenerate

    assign g_rd = rd_en && (rd_addr == GADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q   <= '0;
            gch_q <= '0;
        end else if (wr) begin
            g_q   <= '{done: 1'b1,
                       ovr:  (g_q.ovr && !g_rd) | (wr_scan & g_q.done & !g_rd),
                       val:  wr_val};
            gch_q <= wr_ch;
        end else if (g_rd) begin
            g_q.done <= 1'b0;
            g_q.ovr  <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == GADDR)
            rd_data = pack_word(g_q.done, g_q.ovr, gch_q, g_q.val);
        else if (rd_addr < GADDR)
            rd_data = pack_word(slot_v[rd_addr[CW-1:0]].done, slot_v[rd_addr[CW-1:0]].ovr,
                                '0, slot_v[rd_addr[CW-1:0]].val);
    end

    // R11
    ovr_over_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(g_q.ovr) |-> $past(g_q.done));

    // R10
    glob_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (g_rd && !wr) |=> (!g_q.done && !g_q.ovr));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [CTRLW-1:0] ctrl_wdata,
    input  logic [NCH-1:0]   irq_en,
    input  logic             rd_en,
    input  logic [CHW:0]     rd_addr,
    input  logic             cmp_in,
    output logic [WORDW-1:0] rd_data,
    output logic             conv_tick,
    output logic [CHW-1:0]   mux_sel,
    output logic [RESW-1:0]  trial_code,
    output logic             busy,
    output logic             irq
);
    localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

    ctrl_t           cfg_q;
    ctrl_t           cfg_new;
    logic            sw_pend_q;
    logic [CHW-1:0]  scan_from_q;
    logic [CHW-1:0]  pick_ch;
    logic            core_busy;
    logic            scan_ok;
    logic            launch;
    logic            done_pulse;
    logic [CHW-1:0]  done_ch;
    logic [RESW-1:0] done_val;
    logic [NCH-1:0]  ch_done;

    assign cfg_new = ctrl_t'(ctrl_wdata);
    assign scan_ok = cfg_q.scan && (cfg_q.go == '0);
    assign pick_ch = next_set(cfg_q.mask, sw_pend_q ? '0 : scan_from_q);
    assign launch  = !core_busy && cfg_q.pwr_on && (|cfg_q.mask) && (sw_pend_q || scan_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= '0;
            sw_pend_q   <= 1'b0;
            scan_from_q <= '0;
        end else begin
            if (ctrl_we) begin
                cfg_q       <= cfg_new;
                sw_pend_q   <= (cfg_new.go == GO_NOW) && !cfg_new.scan;
                scan_from_q <= '0;
            end else begin
                if (launch || !cfg_q.pwr_on) sw_pend_q <= 1'b0;
                if (launch && !sw_pend_q)
                    scan_from_q <= (pick_ch == LAST_CH) ? '0 : pick_ch + 1'b1;
            end
        end
    end

    adc_tick_gen #(.DW(DIVW)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg_q.pwr_on),
        .div  (cfg_q.div),
        .tick (conv_tick)
    );

    adc_sar_core #(.RW(RESW), .CW(CHW), .RC(RCW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_ch  (pick_ch),
        .launch_res (cfg_q.res),
        .tick       (conv_tick),
        .abort      (!cfg_q.pwr_on),
        .cmp_in     (cmp_in),
        .busy       (core_busy),
        .mux_ch     (mux_sel),
        .trial      (trial_code),
        .done_pulse (done_pulse),
        .done_ch    (done_ch),
        .done_val   (done_val)
    );

    adc_result_bank #(.N(NCH), .CW(CHW), .RW(RESW), .AW(CHW + 1)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (done_pulse),
        .wr_ch   (done_ch),
        .wr_val  (done_val),
        .wr_scan (cfg_q.scan),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ch_done (ch_done)
    );

    assign busy = core_busy;
    assign irq  = |(ch_done & irq_en);

    // R6 R7
    no_stray_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (!core_busy && !sw_pend_q && !scan_ok) |=> !core_busy);

    // R8
    pwr_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.pwr_on |=> !core_busy);
endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [23:0] ctrl_wdata = '0;
    logic [7:0]  irq_en = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        cmp_in;
    logic [31:0] rd_data;
    logic        conv_tick;
    logic [2:0]  mux_sel;
    logic [9:0]  trial_code;
    logic        busy;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [9:0] analog [8];

    always #2.5 clk = ~clk;

    // comparator and input levels
    assign cmp_in = (analog[mux_sel] >= trial_code);

    adc_scan_seq dut_i (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .irq_en(irq_en), .rd_en(rd_en), .rd_addr(rd_addr), .cmp_in(cmp_in),
        .rd_data(rd_data), .conv_tick(conv_tick), .mux_sel(mux_sel),
        .trial_code(trial_code), .busy(busy), .irq(irq)
    );

    function automatic void chk(input bit ok, input string tag,
                                input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    function automatic logic [31:0] word(input bit done, input bit ovr,
                                         input logic [2:0] ch, input logic [9:0] val);
        logic [31:0] w;
        w = '0;
        w[31] = done;
        w[30] = ovr;
        w[26:24] = ch;
        w[15:6] = val;
        return w;
    endfunction

    function automatic logic [9:0] trunc(input logic [9:0] a, input int code);
        return (a >> code) << code;
    endfunction

    // behavioural model of the divided tick
    int mcnt = 0;
    bit m_pwr = 0;
    int m_div = 0;
    always @(posedge clk) begin
        if (rst) begin
            mcnt = 0; m_pwr = 0; m_div = 0;
        end else begin
            if (!m_pwr || (mcnt >= m_div)) mcnt = 0;
            else mcnt++;
            if (ctrl_we) begin
                m_pwr = ctrl_wdata[20];
                m_div = int'(ctrl_wdata[15:8]);
            end
        end
    end

    // per-clock comparison and conversion tracking
    bit busy_prev = 0;
    int tick_in_conv = 0;
    int last_ticks = 0;
    int conv_done_cnt = 0;
    int order[$];
    always @(negedge clk) begin
        if (!rst) begin
            chk(conv_tick == (m_pwr && (mcnt >= m_div)), "R1 tick", 32'(conv_tick),
                32'(m_pwr && (mcnt >= m_div)));
            if (busy && !busy_prev) begin
                order.push_back(int'(mux_sel));
                tick_in_conv = 0;
            end
            if (busy && conv_tick) tick_in_conv++;
            if (!busy && busy_prev) begin
                last_ticks = tick_in_conv;
                conv_done_cnt++;
            end
            busy_prev = busy;
        end
    end

    task automatic wr_ctrl(input logic [7:0] mask, input logic [7:0] div, input bit scan,
                           input logic [2:0] res, input bit pwr, input logic [2:0] go);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = {go, pwr, res, scan, div, mask};
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_done(input int n0);
        for (int i = 0; i < 20000 && conv_done_cnt == n0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic sw_conv(input logic [7:0] mask, input logic [7:0] div, input logic [2:0] res);
        int n0;
        n0 = conv_done_cnt;
        wr_ctrl(mask, div, 1'b0, res, 1'b1, 3'b001);
        wait_done(n0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n0;
        analog[0] = 10'h3FF; analog[1] = 10'h2A5; analog[2] = 10'h000; analog[3] = 10'h155;
        analog[4] = 10'h1FF; analog[5] = 10'h200; analog[6] = 10'h0F0; analog[7] = 10'h37C;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk(!busy && !irq, "R12 reset", {30'd0, busy, irq}, 0);
        rd(4'd8, d);
        chk(d == 0, "R9 reset global", d, 0);

        // R2 R3 R4: single conversion of input 1 at full resolution
        order.delete();
        sw_conv(8'h02, 8'd1, 3'd0);
        chk(order.size() == 1, "R2 one conversion", order.size(), 1);
        if (order.size() > 0) chk(order[0] == 1, "R2 lowest mask input", order[0], 1);
        chk(last_ticks == 11, "R3 ticks at code 0", last_ticks, 11);
        rd(4'd1, d);
        chk(d == word(1, 0, 0, 10'h2A5), "R4 input 1 result", d, word(1, 0, 0, 10'h2A5));
        rd(4'd8, d);
        chk(d == word(1, 0, 1, 10'h2A5), "R9 global layout", d, word(1, 0, 1, 10'h2A5));
        rd(4'd8, d);
        chk(d == word(0, 0, 1, 10'h2A5), "R10 global cleared", d, word(0, 0, 1, 10'h2A5));
        rd(4'd1, d);
        chk(d[31] == 1'b0, "R10 input register cleared", d, 0);

        // R3: code 3 on input 7, code 7 on input 4
        sw_conv(8'h80, 8'd4, 3'd3);
        chk(last_ticks == 8, "R3 ticks at code 3", last_ticks, 8);
        sw_conv(8'h10, 8'd0, 3'd7);
        chk(last_ticks == 4, "R3 ticks at code 7", last_ticks, 4);

        // R12 interrupt masking
        irq_en = 8'h10;
        @(negedge clk);
        chk(irq == 1'b1, "R12 enabled input done", irq, 1);
        rd(4'd4, d);
        chk(d == word(1, 0, 0, trunc(10'h1FF, 7)), "R3 three-bit result", d,
            word(1, 0, 0, trunc(10'h1FF, 7)));
        @(negedge clk);
        chk(irq == 1'b0, "R12 cleared by read", irq, 0);
        irq_en = 8'h80;
        @(negedge clk);
        chk(irq == 1'b1, "R12 second input", irq, 1);
        rd(4'd7, d);
        chk(d == word(1, 0, 0, trunc(10'h37C, 3)), "R3 seven-bit result", d,
            word(1, 0, 0, trunc(10'h37C, 3)));
        irq_en = 8'h02;
        sw_conv(8'h01, 8'd2, 3'd0);
        chk(irq == 1'b0, "R12 masked input", irq, 0);
        rd(4'd0, d);
        chk(d == word(1, 0, 0, 10'h3FF), "R4 full-scale input", d, word(1, 0, 0, 10'h3FF));
        irq_en = 8'h00;

        // R5 R6 R11: continuous scan over inputs 2, 5, 7
        rd(4'd8, d);
        order.delete();
        n0 = conv_done_cnt;
        wr_ctrl(8'hA4, 8'd0, 1'b1, 3'd7, 1'b1, 3'b000);
        for (int i = 0; i < 5000 && order.size() < 5; i++) @(negedge clk);
        wr_ctrl(8'hA4, 8'd0, 1'b0, 3'd7, 1'b1, 3'b000);
        repeat (60) @(negedge clk);
        chk(order.size() == 5, "R6 no conversion after stop", order.size(), 5);
        chk(conv_done_cnt - n0 == 5, "R6 last conversion finished", conv_done_cnt - n0, 5);
        chk(!busy, "R6 idle after stop", busy, 0);
        if (order.size() == 5) begin
            chk(order[0] == 2 && order[1] == 5 && order[2] == 7, "R5 ascending order",
                {order[0][7:0], order[1][7:0], order[2][7:0]}, 32'h020507);
            chk(order[3] == 2 && order[4] == 5, "R5 wrap to lowest",
                {order[3][7:0], order[4][7:0]}, 32'h0205);
        end
        rd(4'd2, d);
        chk(d == word(1, 1, 0, 10'h000), "R11 input overrun", d, word(1, 1, 0, 10'h000));
        rd(4'd2, d);
        chk(d == word(0, 0, 0, 10'h000), "R10 overrun cleared", d, 0);
        rd(4'd7, d);
        chk(d == word(1, 0, 0, trunc(10'h37C, 7)), "R5 input 7 once", d,
            word(1, 0, 0, trunc(10'h37C, 7)));
        rd(4'd8, d);
        chk(d == word(1, 1, 5, trunc(10'h200, 7)), "R11 global overrun", d,
            word(1, 1, 5, trunc(10'h200, 7)));

        // R7: scan with a non-zero start code
        order.delete();
        wr_ctrl(8'h01, 8'd0, 1'b1, 3'd0, 1'b1, 3'b001);
        repeat (60) @(negedge clk);
        chk(order.size() == 0 && !busy, "R7 blocked scan", order.size(), 0);

        // R8: powered off
        wr_ctrl(8'h01, 8'd0, 1'b0, 3'd0, 1'b0, 3'b001);
        repeat (60) @(negedge clk);
        chk(order.size() == 0, "R8 no conversion", order.size(), 0);
        chk(conv_tick == 1'b0, "R8 no tick", conv_tick, 0);

        // R8: power-down aborts a conversion in progress
        wr_ctrl(8'h08, 8'd7, 1'b0, 3'd0, 1'b1, 3'b001);
        for (int i = 0; i < 200 && order.size() == 0; i++) @(negedge clk);
        wr_ctrl(8'h08, 8'd7, 1'b0, 3'd0, 1'b0, 3'b000);
        repeat (5) @(negedge clk);
        chk(!busy, "R8 aborted", busy, 0);
        rd(4'd3, d);
        chk(d == 0, "R8 no result stored", d, 0);

        // R1 R4: another divider and resolution
        sw_conv(8'h40, 8'd5, 3'd2);
        chk(last_ticks == 9, "R3 ticks at code 2", last_ticks, 9);
        rd(4'd6, d);
        chk(d == word(1, 0, 0, trunc(10'h0F0, 2)), "R4 input 6 result", d,
            word(1, 0, 0, trunc(10'h0F0, 2)));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule